// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Counter

The block is a chain of identical 4-bit binary counter slices. Every slice runs on the rising edge of one shared clock. A shared active-low synchronous clear and a shared active-low synchronous parallel load act on all slices at that edge. Each slice has two count enables. The first, the parallel enable, goes to every slice from one global enable. The second, the trickle enable, also gates the slice's ripple-carry output. The trickle enable of each slice is driven by the ripple carry of the slice below it, so the chain behaves as one wide synchronous binary counter with no added gating.

The carry of the top slice is brought out as a terminal-count flag. Because clear is synchronous, the user can shorten the count length by decoding the outputs for the last wanted value and driving clear low from that decode. The counter then runs modulo M.

Top module: `cascade_counter`

## Requirements
- R1: The outputs change only at a rising clock edge. A change on the enables, the load input or the data input between edges leaves `q` unchanged until the next rising edge.
- R2: If `clr_n` is 0 at a rising edge, `q` becomes 0 after that edge. This holds whatever the levels of `load_n`, `en_all` and `data_in`, so clear wins over load and over counting.
- R3: If `load_n` is 0 and `clr_n` is 1 at a rising edge, `q` takes the value of `data_in` after that edge. This holds whatever the level of `en_all`.
- R4: If `clr_n`, `load_n` and `en_all` are all 1 at a rising edge, `q` becomes the old `q` plus one, counted as a single unsigned binary number of SLICES*4 bits.
- R5: If `clr_n` and `load_n` are 1 and `en_all` is 0 at a rising edge, `q` keeps its value.
- R6: When `q` is all ones, an enabled counting edge wraps `q` to 0.
- R7: `tc_out` is 1 exactly when `en_all` is 1 and every bit of `q` is 1. It is combinational and follows `en_all` without waiting for a clock edge.
- R8: A slice above the lowest counts only at an edge where every slice below it holds 1111. A carry therefore reaches across three or more slices in one cycle.
- R9: When `clr_n` is driven by a decode that goes low at the value M-1, the counter runs 0, 1, …, M-1 and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all slices |
| clr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_all | input | 1 | Global count enable; feeds every parallel enable and the trickle enable of slice 0 |
| data_in | input | SLICES*SLICE_W | Word loaded when `load_n` is low |
| q | output | SLICES*SLICE_W | Count value; slice 0 in the low bits |
| tc_out | output | 1 | Terminal count: the ripple carry of the top slice |

## Verification
The bench targets the wrap from all ones to zero. A design that lost the top carry there would stick at all ones or jump to a wrong value.

It also targets carries that cross three slices at once (0x0FFF to 0x1000). A chain whose enable skipped a slice would leave a middle nibble stale.

It drives clear and load together, and drives clear with the enable low. This exposes a wrong priority, which shows up as the data word appearing instead of zero.

Finally, it changes the global enable between edges to confirm two things. The terminal-count flag must move at once, with no clock edge. The count itself must not move until the next edge.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;

  typedef enum logic [1:0] {
    M_HOLD  = 2'd0,
    M_INC   = 2'd1,
    M_LOAD  = 2'd2,
    M_CLEAR = 2'd3
  } slice_mode_e;

  // Priority: clear, then load, then counting (both enables needed).
  function automatic slice_mode_e pick_mode(input logic clr_n, input logic load_n,
                                            input logic enp, input logic ent);
    if (!clr_n)          return M_CLEAR;
    else if (!load_n)    return M_LOAD;
    else if (enp && ent) return M_INC;
    return M_HOLD;
  endfunction

endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cascade_counter_pkg::*;
(
  input  logic        clr_n,
  input  logic        load_n,
  input  logic        enp,
  input  logic        ent,
  output slice_mode_e mode
);
  always_comb mode = pick_mode(clr_n, load_n, enp, ent);
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         ent,
  output logic         rco
);
  logic at_top;
  assign at_top = &cur;
  assign rco    = ent & at_top;
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cascade_counter_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         enp,
  input  logic         ent,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rco
);
  slice_mode_e  mode;
  logic [W-1:0] cnt_r;
  logic [W-1:0] cnt_nxt;

  cnt_mode_dec u_dec (
    .clr_n (clr_n),
    .load_n(load_n),
    .enp   (enp),
    .ent   (ent),
    .mode  (mode)
  );

  always_comb begin
    case (mode)
      M_CLEAR: cnt_nxt = '0;
      M_LOAD:  cnt_nxt = d;
      M_INC:   cnt_nxt = cnt_r + 1'b1;
      default: cnt_nxt = cnt_r;
    endcase
  end

  always_ff @(posedge clk) cnt_r <= cnt_nxt;

  cnt_carry #(.W(W)) u_carry (
    .cur(cnt_r),
    .ent(ent),
    .rco(rco)
  );

  assign q = cnt_r;
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int SLICES  = 4,
  parameter int SLICE_W = 4
) (
  input  logic                        clk,
  input  logic                        clr_n,
  input  logic                        load_n,
  input  logic                        en_all,
  input  logic [SLICES*SLICE_W-1:0]   data_in,
  output logic [SLICES*SLICE_W-1:0]   q,
  output logic                        tc_out
);
  localparam int TOT_W = SLICES * SLICE_W;

  logic [SLICES-1:0] slice_ent;
  logic [SLICES-1:0] slice_rco;

  genvar k;
  generate
    for (k = 0; k < SLICES; k++) begin : g_slice
      if (k == 0) begin : g_first
        assign slice_ent[k] = en_all;
      end else begin : g_rest
        assign slice_ent[k] = slice_rco[k-1];
      end

      cnt_slice #(.W(SLICE_W)) u_slice (
        .clk   (clk),
        .clr_n (clr_n),
        .load_n(load_n),
        .enp   (en_all),
        .ent   (slice_ent[k]),
        .d     (data_in[k*SLICE_W +: SLICE_W]),
        .q     (q[k*SLICE_W +: SLICE_W]),
        .rco   (slice_rco[k])
      );
    end
  endgenerate

  assign tc_out = slice_rco[SLICES-1];
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int SLICES  = 4,
  parameter int SLICE_W = 4
) (
  input logic                      clk,
  input logic                      clr_n,
  input logic                      load_n,
  input logic                      en_all,
  input logic [SLICES*SLICE_W-1:0] data_in,
  input logic [SLICES*SLICE_W-1:0] q,
  input logic                      tc_out
);
  localparam int TOT_W = SLICES * SLICE_W;

  logic primed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) primed <= 1'b1;

  // R2
  clear_wins_chk: assert property (@(posedge clk) disable iff (!primed)
    !clr_n |=> (q == '0));

  // R3
  load_copies_chk: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && !load_n) |=> (q == $past(data_in)));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && load_n && en_all) |=> (q == TOT_W'($past(q) + 1'b1)));

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && load_n && !en_all) |=> $stable(q));

  // R7
  tc_match_chk: assert property (@(posedge clk) disable iff (!primed)
    tc_out == (en_all && (q == {TOT_W{1'b1}})));
endmodule

bind cascade_counter cascade_counter_chk #(.SLICES(SLICES), .SLICE_W(SLICE_W)) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .load_n (load_n),
  .en_all (en_all),
  .data_in(data_in),
  .q      (q),
  .tc_out (tc_out)
);

// File: tb/cascade_counter_tb.sv
module cascade_counter_tb;
  localparam int CLK_P  = 10;
  localparam int SLICES = 4;
  localparam int SW     = 4;
  localparam int TW     = SLICES * SW;
  localparam int MOD_M  = 10;

  logic          clk = 1'b0;
  logic          clr_reg = 1'b0;
  logic          ld_n = 1'b1;
  logic          en = 1'b0;
  logic          mod_on = 1'b0;
  logic [TW-1:0] din = '0;
  logic [TW-1:0] q;
  logic          tc;
  logic          clr_n;
  logic [TW-1:0] exp_q = '0;
  int            errors = 0;
  int            checks = 0;

  always #(CLK_P/2) clk = ~clk;

  assign clr_n = mod_on ? (q != TW'(MOD_M - 1)) : clr_reg;

  cascade_counter #(.SLICES(SLICES), .SLICE_W(SW)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(ld_n), .en_all(en),
    .data_in(din), .q(q), .tc_out(tc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Drive one cycle, predict, clock, check q and the terminal count.
  task automatic step(input string tag, input logic c, input logic l, input logic e,
                      input logic [TW-1:0] d);
    clr_reg = c; ld_n = l; en = e; din = d;
    if (!c)      exp_q = '0;
    else if (!l) exp_q = d;
    else if (e)  exp_q = exp_q + 1;
    @(posedge clk); #1;
    chk(tag, 32'(q), 32'(exp_q));
    chk("R7 tc", 32'(tc), 32'(en && (exp_q == {TW{1'b1}})));
  endtask

  task automatic t_reset;
    step("R2 reset clear", 1'b0, 1'b1, 1'b0, 16'h5A5A);
    step("R2 reset clear hold", 1'b0, 1'b0, 1'b1, 16'h1234);
  endtask

  task automatic t_load;
    step("R3 load en low", 1'b1, 1'b0, 1'b0, 16'hBEEF);
    step("R3 load en high", 1'b1, 1'b0, 1'b1, 16'h0042);
  endtask

  task automatic t_hold_between_edges;
    step("R5 hold", 1'b1, 1'b1, 1'b0, 16'h0000);
    // R1: change inputs mid-cycle, q must not move before the edge
    @(negedge clk);
    en = 1'b1; ld_n = 1'b0; din = 16'h7777;
    #1;
    chk("R1 no change between edges", 32'(q), 32'(exp_q));
    ld_n = 1'b1; en = 1'b0;
    step("R5 hold again", 1'b1, 1'b1, 1'b0, 16'h7777);
  endtask

  task automatic t_wrap;
    step("R3 load all ones", 1'b1, 1'b0, 1'b0, 16'hFFFF);
    chk("R7 tc low with en low", 32'(tc), 32'd0);
    en = 1'b1; #1;
    chk("R7 tc follows en without clock", 32'(tc), 32'd1);
    step("R6 wrap to zero", 1'b1, 1'b1, 1'b1, 16'h0000);
    step("R4 count after wrap", 1'b1, 1'b1, 1'b1, 16'h0000);
  endtask

  task automatic t_cascade;
    step("R3 load 0FFE", 1'b1, 1'b0, 1'b0, 16'h0FFE);
    step("R4 count 0FFF", 1'b1, 1'b1, 1'b1, 16'h0);
    step("R8 carry over three slices", 1'b1, 1'b1, 1'b1, 16'h0);
    step("R3 load 00FF", 1'b1, 1'b0, 1'b0, 16'h00FF);
    step("R8 carry over two slices", 1'b1, 1'b1, 1'b1, 16'h0);
    step("R3 load 10EF", 1'b1, 1'b0, 1'b0, 16'h10EF);
    step("R8 middle nibble stays", 1'b1, 1'b1, 1'b1, 16'h0);
  endtask

  task automatic t_clear_priority;
    step("R3 load before clear", 1'b1, 1'b0, 1'b1, 16'h3C3C);
    step("R2 clear beats load", 1'b0, 1'b0, 1'b1, 16'h9999);
    step("R3 load mid count", 1'b1, 1'b0, 1'b1, 16'h0123);
    step("R2 clear with en low", 1'b0, 1'b1, 1'b0, 16'h0);
  endtask

  task automatic t_modulo;
    clr_reg = 1'b1; ld_n = 1'b1; en = 1'b1; mod_on = 1'b1;
    for (int i = 0; i < 3 * MOD_M; i++) begin
      if (exp_q == TW'(MOD_M - 1)) exp_q = '0;
      else                         exp_q = exp_q + 1;
      @(posedge clk); #1;
      chk("R9 modulo count", 32'(q), 32'(exp_q));
    end
    mod_on = 1'b0; en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    t_reset();
    t_load();
    t_hold_between_edges();
    t_wrap();
    t_cascade();
    t_clear_priority();
    t_modulo();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule